// File: doc/BRIEF.md
# Asynchronous Schedule Empty Detector

A host controller walks a circular list of queue heads once the periodic work of a micro-frame is done. This block watches that walk and decides when another pass would gain nothing. It keeps a sticky progress flag, called the reclamation flag, that software can read. Defined start events set the flag, and so does every transaction executed while the asynchronous list is being walked. Each fetch of the queue head that marks the head of the list clears it. If that marker head is fetched while the flag is already clear, no progress has been made for a whole lap. The block then pulses a sleep request and the traversal engine goes idle.

While asleep, a counter runs against a programmable delay. When the delay has passed and enough of the micro-frame is left, the block pulses a restart request. That restart counts as a start event and sets the flag again. Every micro-frame start ends any sleep. The periodic schedule runs first when it is enabled. When it is disabled, the micro-frame start itself begins asynchronous traversal. When the asynchronous schedule is disabled, the flag is held clear and no requests are raised.

A parameter selects whether the flag is also cleared while the periodic schedule is being processed.

Top module: `async_sched_idle_ctl`

## Requirements
- R1: When `periodic_done` arrives during periodic processing with `async_en` high, the block enters asynchronous traversal and `recl_flag` reads 1 one cycle later.
- R2: A `uframe_start` with `per_en` low and `async_en` high enters asynchronous traversal and sets `recl_flag` (visible the next cycle).
- R3: `txn_exec` during asynchronous traversal sets `recl_flag`. `txn_exec` outside asynchronous traversal does not set it.
- R4: A fetch with `qh_fetch`=1 and `qh_head`=1 during asynchronous traversal clears `recl_flag` the next cycle, unless a set happens in the same cycle.
- R5: A head-marker fetch (`qh_fetch`=1, `qh_head`=1) seen while `recl_flag` is already 0 and with no `txn_exec` in that cycle gives a one-cycle `sleep_req` pulse on the next cycle, and `asleep` goes to 1.
- R6: When `txn_exec` and a head-marker fetch arrive in the same cycle, the flag ends up 1 and no `sleep_req` is raised.
- R7: While asleep, the block pulses `restart_req` after `wake_dly`+1 sleep cycles, provided time is left in the micro-frame. The pulse leaves sleep and sets `recl_flag` in the same cycle.
- R8: Time is left only while the cycle count since the last `uframe_start` is below `UFRAME_LEN`-`GUARD`. Past that point no `restart_req` is raised and the block stays asleep.
- R9: `uframe_start` always ends sleep or idling. With `per_en` high it enters periodic processing, which does not set the flag.
- R10: While `async_en` is 0, `recl_flag` is 0 on the following cycle and neither `sleep_req` nor `restart_req` is raised.
- R11: With `CLR_IN_PERIODIC`=1, each cycle of periodic processing clears `recl_flag`. With 0, the flag holds its value during periodic processing.
- R12: After reset, `recl_flag`, `sleep_req`, `restart_req` and `asleep` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_en | input | 1 | Periodic schedule enabled |
| async_en | input | 1 | Asynchronous schedule enabled |
| uframe_start | input | 1 | Micro-frame start strobe |
| periodic_done | input | 1 | Periodic processing for this micro-frame finished |
| qh_fetch | input | 1 | A queue head was fetched this cycle |
| qh_head | input | 1 | The fetched queue head carries the head-of-list marker |
| txn_exec | input | 1 | A transaction was executed this cycle |
| wake_dly | input | DLY_W | Sleep cycles before a restart is allowed |
| recl_flag | output | 1 | Reclamation (progress) flag |
| sleep_req | output | 1 | One-cycle pulse: schedule found empty, idle traversal |
| restart_req | output | 1 | One-cycle pulse: resume asynchronous traversal |
| asleep | output | 1 | Asynchronous traversal is sleeping |

## Verification
The checker tests on every cycle the relations that local history can decide:
- a disabled asynchronous schedule forces the flag clear and suppresses both requests;
- a sleep pulse is always preceded by a marker fetch with the flag already clear and no transaction;
- a transaction during traversal always leaves the flag set;
- a restart pulse lasts one cycle and comes with the flag set;
- a micro-frame start with periodic enabled leads to periodic processing.

Other behaviours depend on long runs of cycles or on comparing configurations, so only the bench scenarios show them:
- the exact restart delay;
- the refusal to restart late in the micro-frame;
- the full lap sequence of clear, then empty, then sleep;
- the difference made by the periodic-clear option.

// File: rtl/asd_pkg.sv
package asd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_PERIODIC = 2'd1,
        PH_ASYNC    = 2'd2,
        PH_SLEEP    = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   sleep_req;
        logic   restart_req;
    } fsm_state_t;

endpackage

// File: rtl/asd_wake_timer.sv
module asd_wake_timer
    import asd_pkg::*;
#(
    parameter int UFRAME_LEN = 7500,
    parameter int GUARD      = 500,
    parameter int DLY_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uframe_start,
    input  phase_e           phase_q,
    input  logic [DLY_W-1:0] wake_dly,
    output logic             time_ok,
    output logic             wake_fire
);

    localparam int UF_W     = $clog2(UFRAME_LEN + 1);
    localparam int UF_LIMIT = UFRAME_LEN - GUARD;
    localparam logic [UF_W-1:0]  UF_MAX  = UF_W'(UFRAME_LEN - 1);
    localparam logic [UF_W-1:0]  UF_THR  = UF_W'(UF_LIMIT);
    localparam logic [DLY_W-1:0] SLP_MAX = {DLY_W{1'b1}};

    typedef struct packed {
        logic [UF_W-1:0]  uf_cnt;
        logic [DLY_W-1:0] slp_cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic in_sleep;

    assign in_sleep = (phase_q == PH_SLEEP);

    always_comb begin
        tmr_d = tmr_q;

        // Micro-frame position counter, saturating at the frame length.
        if (uframe_start) begin
            tmr_d.uf_cnt = '0;
        end else if (tmr_q.uf_cnt < UF_MAX) begin
            tmr_d.uf_cnt = tmr_q.uf_cnt + 1'b1;
        end

        // Sleep duration counter, cleared whenever not sleeping.
        if (!in_sleep) begin
            tmr_d.slp_cnt = '0;
        end else if (tmr_q.slp_cnt != SLP_MAX) begin
            tmr_d.slp_cnt = tmr_q.slp_cnt + 1'b1;
        end
    end

    assign time_ok   = (tmr_q.uf_cnt < UF_THR);
    assign wake_fire = in_sleep && (tmr_q.slp_cnt >= wake_dly) && time_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/asd_phase_fsm.sv
module asd_phase_fsm
    import asd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   uframe_start,
    input  logic   periodic_done,
    input  logic   per_en,
    input  logic   async_en,
    input  logic   qh_fetch,
    input  logic   qh_head,
    input  logic   txn_exec,
    input  logic   recl_q,
    input  logic   wake_fire,
    output phase_e phase_q,
    output logic   start_evt,
    output logic   sleep_req,
    output logic   restart_req
);

    fsm_state_t st_d, st_q;
    logic       head_seen;
    logic       empty_evt;

    assign head_seen = qh_fetch && qh_head;
    assign empty_evt = async_en && (st_q.phase == PH_ASYNC) && head_seen
                       && !recl_q && !txn_exec;

    always_comb begin
        st_d             = st_q;
        st_d.sleep_req   = 1'b0;
        st_d.restart_req = 1'b0;
        start_evt        = 1'b0;

        if (uframe_start) begin
            // A new micro-frame always ends idling or sleep.
            if (per_en) begin
                st_d.phase = PH_PERIODIC;
            end else if (async_en) begin
                st_d.phase = PH_ASYNC;
                start_evt  = 1'b1;
            end else begin
                st_d.phase = PH_IDLE;
            end
        end else begin
            unique case (st_q.phase)
                PH_PERIODIC: begin
                    if (periodic_done || !per_en) begin
                        if (async_en) begin
                            st_d.phase = PH_ASYNC;
                            start_evt  = 1'b1;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end
                end
                PH_ASYNC: begin
                    if (!async_en) begin
                        st_d.phase = PH_IDLE;
                    end else if (empty_evt) begin
                        st_d.phase     = PH_SLEEP;
                        st_d.sleep_req = 1'b1;
                    end
                end
                PH_SLEEP: begin
                    if (!async_en) begin
                        st_d.phase = PH_IDLE;
                    end else if (wake_fire) begin
                        st_d.phase       = PH_ASYNC;
                        st_d.restart_req = 1'b1;
                        start_evt        = 1'b1;
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase       <= PH_IDLE;
            st_q.sleep_req   <= 1'b0;
            st_q.restart_req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q     = st_q.phase;
    assign sleep_req   = st_q.sleep_req;
    assign restart_req = st_q.restart_req;

endmodule

// File: rtl/asd_recl_flag.sv
module asd_recl_flag
    import asd_pkg::*;
#(
    parameter bit CLR_IN_PERIODIC = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   async_en,
    input  phase_e phase_q,
    input  logic   start_evt,
    input  logic   txn_exec,
    input  logic   qh_fetch,
    input  logic   qh_head,
    output logic   recl_q
);

    logic recl_d;
    logic set_hit;
    logic head_clr;
    logic per_clr;

    generate
        if (CLR_IN_PERIODIC) begin : g_per_clr
            assign per_clr = (phase_q == PH_PERIODIC);
        end else begin : g_no_per_clr
            assign per_clr = 1'b0;
        end
    endgenerate

    assign set_hit  = start_evt || (txn_exec && (phase_q == PH_ASYNC));
    assign head_clr = qh_fetch && qh_head && (phase_q == PH_ASYNC);

    always_comb begin
        recl_d = recl_q;
        if (!async_en) begin
            recl_d = 1'b0;
        end else if (set_hit) begin
            recl_d = 1'b1;           // progress wins over a same-cycle clear
        end else if (head_clr || per_clr) begin
            recl_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recl_q <= 1'b0;
        end else begin
            recl_q <= recl_d;
        end
    end

endmodule

// File: rtl/async_sched_idle_ctl.sv
module async_sched_idle_ctl
    import asd_pkg::*;
#(
    parameter int UFRAME_LEN      = 7500,
    parameter int GUARD           = 500,
    parameter int DLY_W           = 8,
    parameter bit CLR_IN_PERIODIC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_en,
    input  logic             async_en,
    input  logic             uframe_start,
    input  logic             periodic_done,
    input  logic             qh_fetch,
    input  logic             qh_head,
    input  logic             txn_exec,
    input  logic [DLY_W-1:0] wake_dly,
    output logic             recl_flag,
    output logic             sleep_req,
    output logic             restart_req,
    output logic             asleep
);

    phase_e phase_q;
    logic   start_evt;
    logic   wake_fire;
    logic   time_ok;
    logic   recl_q;

    asd_phase_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .uframe_start  (uframe_start),
        .periodic_done (periodic_done),
        .per_en        (per_en),
        .async_en      (async_en),
        .qh_fetch      (qh_fetch),
        .qh_head       (qh_head),
        .txn_exec      (txn_exec),
        .recl_q        (recl_q),
        .wake_fire     (wake_fire),
        .phase_q       (phase_q),
        .start_evt     (start_evt),
        .sleep_req     (sleep_req),
        .restart_req   (restart_req)
    );

    asd_recl_flag #(
        .CLR_IN_PERIODIC (CLR_IN_PERIODIC)
    ) u_recl (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_en  (async_en),
        .phase_q   (phase_q),
        .start_evt (start_evt),
        .txn_exec  (txn_exec),
        .qh_fetch  (qh_fetch),
        .qh_head   (qh_head),
        .recl_q    (recl_q)
    );

    asd_wake_timer #(
        .UFRAME_LEN (UFRAME_LEN),
        .GUARD      (GUARD),
        .DLY_W      (DLY_W)
    ) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .uframe_start (uframe_start),
        .phase_q      (phase_q),
        .wake_dly     (wake_dly),
        .time_ok      (time_ok),
        .wake_fire    (wake_fire)
    );

    assign recl_flag = recl_q;
    assign asleep    = (phase_q == PH_SLEEP);

endmodule

// File: rtl/asd_checker.sv
module asd_checker
    import asd_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   per_en,
    input logic   async_en,
    input logic   uframe_start,
    input logic   qh_fetch,
    input logic   qh_head,
    input logic   txn_exec,
    input logic   recl_flag,
    input logic   sleep_req,
    input logic   restart_req,
    input logic   asleep,
    input phase_e phase
);

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !async_en |=> (!recl_flag && !sleep_req && !restart_req));

    assert_sleep_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> $past(qh_fetch && qh_head && !recl_flag && !txn_exec && async_en));

    assert_sleep_enters_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> asleep);

    assert_txn_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_exec && async_en && phase == PH_ASYNC) |=> recl_flag);

    assert_restart_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> (recl_flag && !asleep));

    assert_restart_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    assert_frame_periodic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uframe_start && per_en) |=> (phase == PH_PERIODIC));

    assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_req && restart_req));

endmodule

bind async_sched_idle_ctl asd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .per_en       (per_en),
    .async_en     (async_en),
    .uframe_start (uframe_start),
    .qh_fetch     (qh_fetch),
    .qh_head      (qh_head),
    .txn_exec     (txn_exec),
    .recl_flag    (recl_flag),
    .sleep_req    (sleep_req),
    .restart_req  (restart_req),
    .asleep       (asleep),
    .phase        (phase_q)
);

// File: tb/async_sched_idle_ctl_tb.sv
`timescale 1ns/1ps
module async_sched_idle_ctl_tb;

    localparam int DLY_W = 8;
    localparam int NVEC  = 28;

    // Row bits: [9]uframe_start [8]periodic_done [7]qh_fetch [6]qh_head
    // [5]txn_exec [4]per_en [3]async_en | expected [2]recl [1]sleep [0]restart
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0000011_000, // 0  idle after reset (R12)
        10'b1000011_000, // 1  frame start, periodic first (R9)
        10'b0100011_100, // 2  periodic done -> async start (R1)
        10'b0010011_100, // 3  ordinary fetch
        10'b0011011_000, // 4  head marker clears (R4)
        10'b0010111_100, // 5  transaction sets (R3)
        10'b0011011_000, // 6  head clears (R4)
        10'b0011011_010, // 7  head with flag clear -> sleep (R5)
        10'b0000011_000, // 8  sleeping (R7)
        10'b0000011_000, // 9
        10'b0000011_000, // 10
        10'b0000011_101, // 11 restart after wake_dly+1 (R7)
        10'b0000011_100, // 12
        10'b0011111_100, // 13 set beats clear (R6)
        10'b0011011_000, // 14 head clears (R4)
        10'b0011111_100, // 15 txn with head at flag 0: no sleep (R6)
        10'b1000001_100, // 16 frame start, periodic off (R2)
        10'b0011001_000, // 17 head clears
        10'b0011001_010, // 18 empty -> sleep (R5)
        10'b1000001_100, // 19 frame start ends sleep (R9)
        10'b0000000_000, // 20 async disabled (R10)
        10'b0011000_000, // 21 head ignored (R10)
        10'b0000100_000, // 22 txn ignored (R10)
        10'b1000010_000, // 23 periodic only (R10)
        10'b0100010_000, // 24
        10'b1000011_000, // 25 periodic entered (R9)
        10'b0000111_000, // 26 txn in periodic does not set (R3)
        10'b0100011_100  // 27 periodic done -> start (R1)
    };

    logic clk = 1'b0;
    logic rst_n;
    logic per_en, async_en, uframe_start, periodic_done;
    logic qh_fetch, qh_head, txn_exec;
    logic [DLY_W-1:0] wake_dly;
    logic recl_flag, sleep_req, restart_req, asleep;
    logic recl_flag_c, sleep_req_c, restart_req_c, asleep_c;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    async_sched_idle_ctl #(.DLY_W(DLY_W), .CLR_IN_PERIODIC(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .per_en(per_en), .async_en(async_en),
        .uframe_start(uframe_start), .periodic_done(periodic_done),
        .qh_fetch(qh_fetch), .qh_head(qh_head), .txn_exec(txn_exec),
        .wake_dly(wake_dly), .recl_flag(recl_flag), .sleep_req(sleep_req),
        .restart_req(restart_req), .asleep(asleep)
    );

    async_sched_idle_ctl #(.DLY_W(DLY_W), .CLR_IN_PERIODIC(1'b1)) u_dut_clr (
        .clk(clk), .rst_n(rst_n), .per_en(per_en), .async_en(async_en),
        .uframe_start(uframe_start), .periodic_done(periodic_done),
        .qh_fetch(qh_fetch), .qh_head(qh_head), .txn_exec(txn_exec),
        .wake_dly(wake_dly), .recl_flag(recl_flag_c), .sleep_req(sleep_req_c),
        .restart_req(restart_req_c), .asleep(asleep_c)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        {uframe_start, periodic_done, qh_fetch, qh_head, txn_exec, per_en, async_en} = v;
    endtask

    task automatic tick(input logic [6:0] v);
        drive(v);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(7'b0000011);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        wake_dly = 8'd3;
        rst_n    = 1'b0;
        drive(7'b0000011);
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "recl", recl_flag, 1'b0);
        chk("R12", "sleep", sleep_req, 1'b0);
        chk("R12", "restart", restart_req, 1'b0);
        chk("R12", "asleep", asleep, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("table row %0d", i);
            tick(VEC[i][9:3]);
            chk(tag, "recl", recl_flag, VEC[i][2]);
            chk(tag, "sleep", sleep_req, VEC[i][1]);
            chk(tag, "restart", restart_req, VEC[i][0]);
        end

        // R7: zero wake delay restarts on the first sleep cycle
        do_reset();
        wake_dly = 8'd0;
        tick(7'b1000001);
        tick(7'b0011001);
        tick(7'b0011001);
        chk("R5", "sleep", sleep_req, 1'b1);
        chk("R5", "asleep", asleep, 1'b1);
        tick(7'b0000001);
        chk("R7", "restart", restart_req, 1'b1);
        chk("R7", "recl", recl_flag, 1'b1);
        chk("R7", "asleep", asleep, 1'b0);

        // R8: late in the micro-frame no restart is raised
        do_reset();
        wake_dly = 8'd3;
        tick(7'b1000001);
        repeat (7100) tick(7'b0000001);
        tick(7'b0011001);
        tick(7'b0011001);
        chk("R8", "sleep", sleep_req, 1'b1);
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 50; k++) begin
                tick(7'b0000001);
                if (restart_req) seen++;
            end
            chk("R8", "no restart late", (seen == 0), 1'b1);
        end
        chk("R8", "still asleep", asleep, 1'b1);
        tick(7'b1000001);
        chk("R9", "frame start wakes", asleep, 1'b0);
        chk("R9", "recl", recl_flag, 1'b1);

        // R11: optional clearing during periodic processing
        do_reset();
        tick(7'b1000001);
        chk("R11", "base recl", recl_flag, 1'b1);
        chk("R11", "clr recl", recl_flag_c, 1'b1);
        tick(7'b1000011);
        tick(7'b0000011);
        chk("R11", "base keeps in periodic", recl_flag, 1'b1);
        chk("R11", "variant clears in periodic", recl_flag_c, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule